// File: doc/BRIEF.md
# Floppy Drive Sense Register Model

This block models the drive end of a floppy disk control link. A host addresses one of sixteen one-bit drive registers with three phase lines and a head-select line. The block returns the addressed bit on a single sense output. The same lines carry control writes, which take effect on the rising edge of a strobe. These writes set the step direction, step the head, switch the motor, eject the disk and clear the disk-switched flag.

Two drive instances sit behind a drive-select input. Each instance keeps the following state:
- a head track counter,
- a step-busy timer,
- a motor flag,
- a disk-present flag,
- a disk-switched flag.

Disk insertion arrives as a one-cycle pulse, and write protection as a level, both per drive. A drive that the `INSTALLED` parameter marks as absent reads as all ones and holds no state.

Top module: `floppy_sense_model`

## Requirements
- R1: The read index is {ph_i[2], ph_i[1], ph_i[0], hsel_i}, with ph_i[2] as the most significant bit. sense_o returns that bit of the drive chosen by drv_sel_i (0 = internal, 1 = external), combinationally.
- R2: A write happens only on a clock where strb_i is 1 and was 0 on the previous clock. The target is ph_i (0 = direction, 1 = step, 2 = motor, 3 = eject, 4 = clear switched flag) and the value is hsel_i. Only the drive chosen by drv_sel_i is written. Holding strb_i high writes nothing more.
- R3: Index 0 reads the step direction, which is written at target 0. After reset it reads 0.
- R4: Writing 0 to target 1 issues one step. Index 2 then reads 0 for STEP_CYCLES clocks and reads 1 after that. A step written while busy is ignored, and writing 1 to target 1 has no effect.
- R5: A step with direction 0 adds one to the track and direction 1 subtracts one, saturating at 0 and at TRACKS-1. Index 5 reads 0 exactly when the track is 0.
- R6: Index 4 reads the motor state active-low (0 = on). Target 2 sets it, with value 0 turning the motor on. After reset the motor is off.
- R7: Index 1 reads 1 when no disk is present. An insert_i pulse makes the disk present. Index 3 reads 0 when wp_i of that drive is 1.
- R8: Index 6 reads the disk-switched flag. Writing 1 to target 3 with a disk present removes the disk and sets the flag. Inserting a disk also sets the flag. A write to target 4 clears it.
- R9: Index 12 reads the drive's DOUBLE_SIDED bit. Index 13 reads 0 when a disk is present, the motor is on and no step is busy. Index 14 reads 0 for an installed drive.
- R10: Indices 7 to 11 and 15 read 1. A drive not marked in INSTALLED reads 1 at every index whatever is written to it.
- R11: After reset a drive has direction 0, track 0, no step busy, motor off, no disk and the switched flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ph_i | input | 3 | Phase lines: upper read index bits, write target |
| hsel_i | input | 1 | Head select: read index LSB, write value |
| strb_i | input | 1 | Write strobe, acts on its rising edge |
| drv_sel_i | input | SEL_W | Drive select (0 internal, 1 external) |
| insert_i | input | NUM_DRV | Per-drive disk insert pulse |
| wp_i | input | NUM_DRV | Per-drive write-protect level |
| sense_o | output | 1 | Addressed sense bit |

## Verification
Every internal state bit reaches the ports only through the one sense bit, and only while the host addresses it. A busy timer that runs too long or too short shows at index 2 within STEP_CYCLES clocks. A track counter that is wrong by one stays hidden until a run of steps crosses track 0, which can be up to TRACKS steps later. For that reason the bench drives long inward and outward runs and compares every index it selects against a cycle model on every clock.

// File: rtl/floppy_sense_pkg.sv
package floppy_sense_pkg;

  typedef enum logic [2:0] {
    WA_DIR    = 3'd0,
    WA_STEP   = 3'd1,
    WA_MOTOR  = 3'd2,
    WA_EJECT  = 3'd3,
    WA_CLR_SW = 3'd4
  } wr_addr_e;

  typedef struct packed {
    logic     valid;
    wr_addr_e addr;
    logic     val;
  } wr_cmd_t;

  localparam logic [3:0] RI_DIR    = 4'd0;
  localparam logic [3:0] RI_NODISK = 4'd1;
  localparam logic [3:0] RI_STEP   = 4'd2;
  localparam logic [3:0] RI_WPROT  = 4'd3;
  localparam logic [3:0] RI_MOTOR  = 4'd4;
  localparam logic [3:0] RI_TRK0   = 4'd5;
  localparam logic [3:0] RI_SWITCH = 4'd6;
  localparam logic [3:0] RI_SIDES  = 4'd12;
  localparam logic [3:0] RI_READY  = 4'd13;
  localparam logic [3:0] RI_INST   = 4'd14;

endpackage

// File: rtl/floppy_strobe_decode.sv
module floppy_strobe_decode
  import floppy_sense_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strb_i,
  input  logic [2:0] ph_i,
  input  logic       hsel_i,
  output wr_cmd_t    cmd_o
);

  logic strb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strb_q <= 1'b0;
    else         strb_q <= strb_i;
  end

  always_comb begin
    cmd_o.valid = strb_i & ~strb_q;
    cmd_o.addr  = wr_addr_e'(ph_i);
    cmd_o.val   = hsel_i;
  end

endmodule

// File: rtl/floppy_head_stepper.sv
module floppy_head_stepper #(
  parameter int unsigned TRACKS      = 80,
  parameter int unsigned STEP_CYCLES = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dir_wr_i,
  input  logic dir_val_i,
  input  logic step_req_i,
  output logic dir_o,
  output logic trk0_o,
  output logic busy_o
);

  localparam int unsigned TRK_W  = (TRACKS > 2) ? $clog2(TRACKS) : 1;
  localparam int unsigned BUSY_W = $clog2(STEP_CYCLES + 1);
  localparam logic [TRK_W-1:0]  TRK_MAX  = TRK_W'(TRACKS - 1);
  localparam logic [BUSY_W-1:0] BUSY_LD  = BUSY_W'(STEP_CYCLES);

  logic              dir_q;
  logic [TRK_W-1:0]  trk_q;
  logic [BUSY_W-1:0] busy_q;
  logic              step_go;

  assign busy_o  = (busy_q != '0);
  assign step_go = step_req_i & ~busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dir_q <= 1'b0;
    else if (dir_wr_i) dir_q <= dir_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trk_q <= '0;
    end else if (step_go) begin
      if (!dir_q && trk_q != TRK_MAX) trk_q <= trk_q + 1'b1;
      else if (dir_q && trk_q != '0)  trk_q <= trk_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_q <= '0;
    else if (step_go) busy_q <= BUSY_LD;
    else if (busy_o)  busy_q <= busy_q - 1'b1;
  end

  assign dir_o  = dir_q;
  assign trk0_o = (trk_q == '0);

endmodule

// File: rtl/floppy_drive_unit.sv
module floppy_drive_unit
  import floppy_sense_pkg::*;
#(
  parameter int unsigned TRACKS      = 80,
  parameter int unsigned STEP_CYCLES = 12,
  parameter logic        TWO_SIDES   = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  wr_cmd_t    cmd_i,
  input  logic       insert_i,
  input  logic       wp_i,
  input  logic [3:0] idx_i,
  output logic       sense_o
);

  logic dir, trk0, busy;
  logic motor_q, present_q, switched_q;
  logic eject_go, insert_go, clr_go;

  floppy_head_stepper #(
    .TRACKS     (TRACKS),
    .STEP_CYCLES(STEP_CYCLES)
  ) u_stepper (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dir_wr_i  (wr_en_i && cmd_i.addr == WA_DIR),
    .dir_val_i (cmd_i.val),
    .step_req_i(wr_en_i && cmd_i.addr == WA_STEP && !cmd_i.val),
    .dir_o     (dir),
    .trk0_o    (trk0),
    .busy_o    (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               motor_q <= 1'b0;
    else if (wr_en_i && cmd_i.addr == WA_MOTOR) motor_q <= ~cmd_i.val;
  end

  assign eject_go  = wr_en_i && cmd_i.addr == WA_EJECT && cmd_i.val && present_q;
  assign insert_go = insert_i && !present_q;
  assign clr_go    = wr_en_i && cmd_i.addr == WA_CLR_SW;

  // eject beats insert beats flag clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      present_q  <= 1'b0;
      switched_q <= 1'b0;
    end else if (eject_go) begin
      present_q  <= 1'b0;
      switched_q <= 1'b1;
    end else if (insert_go) begin
      present_q  <= 1'b1;
      switched_q <= 1'b1;
    end else if (clr_go) begin
      switched_q <= 1'b0;
    end
  end

  always_comb begin
    case (idx_i)
      RI_DIR:    sense_o = dir;
      RI_NODISK: sense_o = ~present_q;
      RI_STEP:   sense_o = ~busy;
      RI_WPROT:  sense_o = ~wp_i;
      RI_MOTOR:  sense_o = ~motor_q;
      RI_TRK0:   sense_o = ~trk0;
      RI_SWITCH: sense_o = switched_q;
      RI_SIDES:  sense_o = TWO_SIDES;
      RI_READY:  sense_o = ~(present_q & motor_q & ~busy);
      RI_INST:   sense_o = 1'b0;
      default:   sense_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/floppy_sense_model.sv
module floppy_sense_model
  import floppy_sense_pkg::*;
#(
  parameter int unsigned         NUM_DRV      = 2,
  parameter int unsigned         TRACKS       = 80,
  parameter int unsigned         STEP_CYCLES  = 12,
  parameter logic [NUM_DRV-1:0]  INSTALLED    = '1,
  parameter logic [NUM_DRV-1:0]  DOUBLE_SIDED = NUM_DRV'(1),
  localparam int unsigned        SEL_W        = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0]         ph_i,
  input  logic               hsel_i,
  input  logic               strb_i,
  input  logic [SEL_W-1:0]   drv_sel_i,
  input  logic [NUM_DRV-1:0] insert_i,
  input  logic [NUM_DRV-1:0] wp_i,
  output logic               sense_o
);

  wr_cmd_t            wr_cmd;
  logic [3:0]         rd_idx;
  logic [NUM_DRV-1:0] sense_vec;

  assign rd_idx = {ph_i, hsel_i};

  floppy_strobe_decode u_decode (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .strb_i(strb_i),
    .ph_i  (ph_i),
    .hsel_i(hsel_i),
    .cmd_o (wr_cmd)
  );

  for (genvar gi = 0; gi < NUM_DRV; gi++) begin : g_drv
    if (INSTALLED[gi]) begin : g_present
      floppy_drive_unit #(
        .TRACKS     (TRACKS),
        .STEP_CYCLES(STEP_CYCLES),
        .TWO_SIDES  (DOUBLE_SIDED[gi])
      ) u_unit (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_en_i (wr_cmd.valid && drv_sel_i == SEL_W'(gi)),
        .cmd_i   (wr_cmd),
        .insert_i(insert_i[gi]),
        .wp_i    (wp_i[gi]),
        .idx_i   (rd_idx),
        .sense_o (sense_vec[gi])
      );
    end else begin : g_absent
      logic unused_in;
      assign unused_in     = insert_i[gi] ^ wp_i[gi];
      assign sense_vec[gi] = 1'b1;
    end
  end

  assign sense_o = (32'(drv_sel_i) < NUM_DRV) ? sense_vec[drv_sel_i] : 1'b1;

endmodule

// File: rtl/floppy_sense_chk.sv
module floppy_sense_chk #(
  parameter int unsigned        NUM_DRV      = 2,
  parameter int unsigned        SEL_W        = 1,
  parameter logic [NUM_DRV-1:0] INSTALLED    = '1,
  parameter logic [NUM_DRV-1:0] DOUBLE_SIDED = '1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       ph_i,
  input logic             hsel_i,
  input logic [SEL_W-1:0] drv_sel_i,
  input logic             sense_o,
  input logic             cmd_valid_i
);

  logic [3:0] idx;
  logic       past_ok;
  logic       inst_sel;
  logic       sides_sel;

  assign idx       = {ph_i, hsel_i};
  assign inst_sel  = (32'(drv_sel_i) < NUM_DRV) ? INSTALLED[drv_sel_i] : 1'b0;
  assign sides_sel = (32'(drv_sel_i) < NUM_DRV) ? DOUBLE_SIDED[drv_sel_i] : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_one_shot_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> !cmd_valid_i);

  assert_unused_ones_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx inside {4'd7, 4'd8, 4'd9, 4'd10, 4'd11, 4'd15}) |-> sense_o);

  assert_absent_ones_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inst_sel |-> sense_o);

  assert_installed_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx == 4'd14) |-> (sense_o == !inst_sel));

  assert_sides_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx == 4'd12 && inst_sel) |-> (sense_o == sides_sel));

  assert_dir_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && idx == 4'd0 && $past(idx) == 4'd0 && $stable(drv_sel_i)
     && !$past(cmd_valid_i)) |-> $stable(sense_o));

  assert_motor_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && idx == 4'd4 && $past(idx) == 4'd4 && $stable(drv_sel_i)
     && !$past(cmd_valid_i)) |-> $stable(sense_o));

  assert_step_done_stays_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && idx == 4'd2 && $past(idx) == 4'd2 && $stable(drv_sel_i)
     && $past(sense_o) && !$past(cmd_valid_i)) |-> sense_o);

endmodule

bind floppy_sense_model floppy_sense_chk #(
  .NUM_DRV     (NUM_DRV),
  .SEL_W       (SEL_W),
  .INSTALLED   (INSTALLED),
  .DOUBLE_SIDED(DOUBLE_SIDED)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ph_i       (ph_i),
  .hsel_i     (hsel_i),
  .drv_sel_i  (drv_sel_i),
  .sense_o    (sense_o),
  .cmd_valid_i(wr_cmd.valid)
);

// File: tb/floppy_sense_model_bench.sv
module floppy_sense_model_bench;

  localparam int STEPS = 12;
  localparam int TRK   = 80;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ph = 3'd0;
  logic       hsel = 1'b0;
  logic       strb = 1'b0;
  logic       dsel = 1'b0;
  logic [1:0] ins = 2'b00;
  logic [1:0] wp = 2'b00;
  logic       sense, sense_half;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  floppy_sense_model #(.TRACKS(TRK), .STEP_CYCLES(STEPS)) u_floppy_sense_model (
    .clk_i(clk), .rst_ni(rst_n), .ph_i(ph), .hsel_i(hsel), .strb_i(strb),
    .drv_sel_i(dsel), .insert_i(ins), .wp_i(wp), .sense_o(sense));

  floppy_sense_model #(.TRACKS(TRK), .STEP_CYCLES(STEPS), .INSTALLED(2'b10))
    u_floppy_sense_model_half (
    .clk_i(clk), .rst_ni(rst_n), .ph_i(ph), .hsel_i(hsel), .strb_i(strb),
    .drv_sel_i(dsel), .insert_i(ins), .wp_i(wp), .sense_o(sense_half));

  // behavioural reference
  int m_dir[2], m_trk[2], m_busy[2], m_motor[2], m_pres[2], m_sw[2];
  bit m_prev;
  bit m_sides[2] = '{1'b1, 1'b0};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev = 0;
      for (int d = 0; d < 2; d++) begin
        m_dir[d] = 0; m_trk[d] = 0; m_busy[d] = 0;
        m_motor[d] = 0; m_pres[d] = 0; m_sw[d] = 0;
      end
    end else begin
      bit rise;
      rise   = strb && !m_prev;
      m_prev = strb;
      for (int d = 0; d < 2; d++) begin
        bit en;
        bit go;
        en = rise && (int'(dsel) == d);
        go = en && ph == 3'd1 && !hsel && m_busy[d] == 0;
        if (m_busy[d] > 0) m_busy[d]--;
        if (go) begin
          m_busy[d] = STEPS;
          if (m_dir[d] == 0 && m_trk[d] < TRK - 1) m_trk[d]++;
          else if (m_dir[d] == 1 && m_trk[d] > 0) m_trk[d]--;
        end
        if (en && ph == 3'd0) m_dir[d] = hsel;
        if (en && ph == 3'd2) m_motor[d] = !hsel;
        if (en && ph == 3'd3 && hsel && m_pres[d] == 1) begin
          m_pres[d] = 0; m_sw[d] = 1;
        end else if (ins[d] && m_pres[d] == 0) begin
          m_pres[d] = 1; m_sw[d] = 1;
        end else if (en && ph == 3'd4) m_sw[d] = 0;
      end
    end
  end

  function automatic bit model_sense(int d, int idx);
    case (idx)
      0:  return m_dir[d] != 0;
      1:  return m_pres[d] == 0;
      2:  return m_busy[d] == 0;
      3:  return !wp[d];
      4:  return m_motor[d] == 0;
      5:  return m_trk[d] != 0;
      6:  return m_sw[d] != 0;
      12: return m_sides[d];
      13: return !(m_pres[d] == 1 && m_motor[d] == 1 && m_busy[d] == 0);
      14: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string tag_of(int idx);
    case (idx)
      0: return "R3";  1: return "R7";  2: return "R4";  3: return "R7";
      4: return "R6";  5: return "R5";  6: return "R8";
      12, 13, 14: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison, both instances
  always @(negedge clk) begin
    #3;
    if (rst_n && !done) begin
      int idx;
      idx = {ph, hsel};
      chk($sformatf("R1/%s idx %0d drv %0d", tag_of(idx), idx, dsel), sense,
          model_sense(int'(dsel), idx));
      chk($sformatf("R10 half idx %0d drv %0d", idx, dsel), sense_half,
          dsel ? model_sense(1, idx) : 1'b1);
    end
  end

  task automatic look(int d, int idx);
    @(negedge clk);
    dsel = d[0]; ph = idx[3:1]; hsel = idx[0];
    #3;
  endtask

  task automatic wr(int d, int addr, int val);
    @(negedge clk);
    dsel = d[0]; ph = addr[2:0]; hsel = val[0]; strb = 1'b1;
    @(negedge clk);
    strb = 1'b0;
  endtask

  task automatic step_wait(int d);
    wr(d, 1, 0);
    repeat (STEPS + 1) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R11 reset state
    look(0, 1);  chk("R11 no disk", sense, 1'b1);
    look(0, 4);  chk("R11 motor off", sense, 1'b1);
    look(0, 5);  chk("R11 track 0", sense, 1'b0);
    look(0, 2);  chk("R11 not busy", sense, 1'b1);
    look(0, 6);  chk("R11 switched clear", sense, 1'b0);
    look(0, 0);  chk("R11 dir 0", sense, 1'b0);

    // R7 insert and protect
    @(negedge clk); wp[0] = 1'b1; ins[0] = 1'b1;
    @(negedge clk); ins[0] = 1'b0;
    look(0, 1);  chk("R7 disk present", sense, 1'b0);
    look(0, 3);  chk("R7 protected", sense, 1'b0);
    look(0, 6);  chk("R8 switched on insert", sense, 1'b1);
    wr(0, 4, 0);
    look(0, 6);  chk("R8 switched cleared", sense, 1'b0);

    // R6 motor, R9 ready
    wr(0, 2, 0);
    look(0, 4);  chk("R6 motor on", sense, 1'b0);
    look(0, 13); chk("R9 ready", sense, 1'b0);

    // R5 saturate at 0, R4 busy window
    wr(0, 0, 1);
    look(0, 0);  chk("R3 dir written", sense, 1'b1);
    wr(0, 1, 0);
    look(0, 2);  chk("R4 busy after step", sense, 1'b0);
    look(0, 13); chk("R9 not ready while busy", sense, 1'b1);
    repeat (STEPS) @(negedge clk);
    look(0, 2);  chk("R4 step complete", sense, 1'b1);
    look(0, 5);  chk("R5 held at track 0", sense, 1'b0);

    wr(0, 0, 0);
    step_wait(0);
    look(0, 5);  chk("R5 track 1", sense, 1'b1);
    wr(0, 1, 1);
    look(0, 2);  chk("R4 value 1 no step", sense, 1'b1);

    // R4 step while busy ignored: track 1 -> 2 only
    wr(0, 1, 0);
    wr(0, 1, 0);
    repeat (STEPS + 1) @(negedge clk);
    wr(0, 0, 1);
    step_wait(0);
    look(0, 5);  chk("R4 busy step ignored (track 1)", sense, 1'b1);
    step_wait(0);
    look(0, 5);  chk("R4 busy step ignored (track 0)", sense, 1'b0);

    // R5 saturate at TRK-1
    wr(0, 0, 0);
    for (int i = 0; i < TRK + 5; i++) step_wait(0);
    wr(0, 0, 1);
    for (int i = 0; i < TRK - 2; i++) step_wait(0);
    look(0, 5);  chk("R5 one above track 0", sense, 1'b1);
    step_wait(0);
    look(0, 5);  chk("R5 saturated at top", sense, 1'b0);

    // R2 held strobe writes once
    @(negedge clk); dsel = 1'b0; ph = 3'd0; hsel = 1'b0; strb = 1'b1;
    @(negedge clk); hsel = 1'b1;
    @(negedge clk); strb = 1'b0;
    look(0, 0);  chk("R2 held strobe single write", sense, 1'b0);

    // R1 drive select, R2 per drive write
    look(1, 4);  chk("R1 drive1 motor off", sense, 1'b1);
    wr(1, 2, 0);
    wr(0, 2, 1);
    look(1, 4);  chk("R2 drive1 motor on", sense, 1'b0);
    look(0, 4);  chk("R1 drive0 motor off", sense, 1'b1);
    look(0, 12); chk("R9 drive0 two sides", sense, 1'b1);
    look(1, 12); chk("R9 drive1 one side", sense, 1'b0);
    look(1, 14); chk("R9 drive1 installed", sense, 1'b0);

    // R8 eject
    wr(0, 3, 1);
    look(0, 1);  chk("R8 ejected", sense, 1'b1);
    look(0, 6);  chk("R8 switched on eject", sense, 1'b1);

    // R10 unused and absent drive
    for (int k = 7; k < 12; k++) begin
      look(0, k); chk("R10 unused index", sense, 1'b1);
    end
    look(0, 15); chk("R10 unused index 15", sense, 1'b1);
    wr(0, 2, 0);
    look(0, 4);  chk("R10 absent drive ignores motor", sense_half, 1'b1);
    look(0, 14); chk("R10 absent drive not installed", sense_half, 1'b1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule